// File: doc/BRIEF.md
# Signed Byte Load Execution Unit

This unit takes a single load instruction word and carries it out from start to finish. The instruction loads one signed byte using a base register plus an offset register. The unit checks the encoding and reads a base value and an offset value from the register file. The base comes from the stack pointer when the base field selects register 31. The offset is widened in the way the instruction's offset-mode field asks for, with no scaling. The unit adds the base and the offset into a 64-bit address, issues a one-byte read, sign-extends the returned byte to 32 or 64 bits and writes the result to the destination register.

Each instruction ends with exactly one outcome: a write-back pulse, an undefined-encoding fault or a stack-pointer alignment fault. A faulting instruction makes no memory access. A destination of register 31 finishes normally but writes nothing. The unit handles one instruction at a time and holds `busy` high while the instruction is in flight.

Top module: `sbload_unit`

## Requirements
- R1: When `busy` is low and `insn_valid` is high at a clock edge, the word is accepted and `busy` is high from the next cycle until the cycle in which the outcome is reported.
- R2: A word is recognised only if (word AND 0xFFA00C00) equals 0x38A00800 and word bit 14 is 1. Any other word raises `flt_undef` with no memory request and no write-back.
- R3: The offset comes from the register selected by bits 20:16, widened by bits 15:13. 010 zero-extends its low 32 bits, 110 sign-extends its low 32 bits, and 011 or 111 use all 64 bits. Bit 12 has no effect, because the offset is never shifted.
- R4: The request address is the base plus the widened offset, modulo 2^64. The base register is selected by bits 9:5.
- R5: When bits 9:5 equal 31, the base is `sp_value` and not a register-file value.
- R6: When the base is `sp_value`, `sp_align_en` is 1 and `sp_value[3:0]` is nonzero, `flt_sp_align` is raised with no memory request and no write-back. An undefined encoding takes priority over this fault.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until a cycle in which `mem_req_ready` is high.
- R8: When word bit 22 is 0, the byte is sign-extended to 64 bits. When bit 22 is 1, it is sign-extended to 32 bits and the upper 32 bits of `wb_data` are zero.
- R9: `wb_en` pulses with `wb_idx` equal to bits 4:0, unless those bits equal 31, in which case no write occurs.
- R10: `mem_req_priv` is 1 when `cur_el` was nonzero at acceptance and 0 otherwise. `mem_req_tagchk` is always 1.
- R11: Exactly one of `wb_en`, `flt_undef` and `flt_sp_align` pulses for one cycle per instruction, in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| busy | output | 1 | Instruction in flight |
| rf_rd_a_idx | output | 5 | Base register index |
| rf_rd_a_data | input | 64 | Base register value (combinational read) |
| rf_rd_b_idx | output | 5 | Offset register index |
| rf_rd_b_data | input | 64 | Offset register value (combinational read) |
| sp_value | input | 64 | Stack pointer |
| sp_align_en | input | 1 | Stack alignment checking enabled |
| cur_el | input | 2 | Current exception level |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 64 | Byte address |
| mem_req_priv | output | 1 | Privileged access |
| mem_req_tagchk | output | 1 | Tag-checked access |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| wb_en | output | 1 | Register write pulse |
| wb_idx | output | 5 | Destination register |
| wb_data | output | 64 | Value written |
| flt_undef | output | 1 | Undefined-encoding fault pulse |
| flt_sp_align | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The properties assume the following about the environment:
- `mem_rsp_valid` rises only after a request handshake has completed.
- The register-file data follows its index within the same cycle.
- `sp_value` and `sp_align_en` stay steady while an instruction is in flight.

The bench responds only after it has seen `mem_req_ready` taken with `mem_req_valid` high. It models the register file as a combinational array. It changes the stack inputs only while `busy` is low. It changes `cur_el` after acceptance on purpose, to show that the privilege level is captured at acceptance.

// File: rtl/sbload_pkg.sv
package sbload_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned BYTE_W    = 8;

  // Fixed encoding bits of the recognised load word.
  localparam logic [INSN_W-1:0] MATCH_VAL  = 32'h38A0_0800;
  localparam logic [INSN_W-1:0] MATCH_MASK = 32'hFFA0_0C00;

  typedef enum logic [1:0] {
    OFS_FULL = 2'd0,
    OFS_ZX32 = 2'd1,
    OFS_SX32 = 2'd2
  } ofs_mode_e;

  typedef struct packed {
    logic                 legal;
    logic                 narrow;
    ofs_mode_e            mode;
    logic [REG_IDX_W-1:0] rm;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rt;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_REQ  = 2'd2,
    ST_RSP  = 2'd3
  } st_e;

endpackage

// File: rtl/sbload_decode.sv
module sbload_decode
  import sbload_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);

  logic fixed_ok;
  logic mode_ok;

  always_comb begin
    fixed_ok   = ((insn & MATCH_MASK) == MATCH_VAL);
    mode_ok    = insn[14];
    dec.legal  = fixed_ok && mode_ok;
    dec.narrow = insn[22];
    dec.rm     = insn[20:16];
    dec.rn     = insn[9:5];
    dec.rt     = insn[4:0];
    unique case (insn[15:13])
      3'b010:  dec.mode = OFS_ZX32;
      3'b110:  dec.mode = OFS_SX32;
      default: dec.mode = OFS_FULL;
    endcase
  end

endmodule

// File: rtl/sbload_agen.sv
module sbload_agen
  import sbload_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic              use_sp,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] ofs_reg,
  input  ofs_mode_e         mode,
  input  logic              align_en,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);

  localparam int unsigned HALF_W = 32;
  localparam int unsigned PAD_W  = ADDR_W - HALF_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    base = use_sp ? sp_val : base_reg;
    unique case (mode)
      OFS_ZX32: ofs_ext = {{PAD_W{1'b0}}, ofs_reg[HALF_W-1:0]};
      OFS_SX32: ofs_ext = {{PAD_W{ofs_reg[HALF_W-1]}}, ofs_reg[HALF_W-1:0]};
      default:  ofs_ext = ofs_reg;
    endcase
    ea = base + ofs_ext;
  end

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign misaligned = 1'b0;
    end else begin : g_align
      assign misaligned = use_sp && align_en && (|sp_val[ALIGN_BITS-1:0]);
    end
  endgenerate

endmodule

// File: rtl/sbload_sext.sv
module sbload_sext
  import sbload_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              narrow,
  output logic [XLEN-1:0]   result
);

  localparam int unsigned WIDE_PAD   = XLEN - BYTE_W;
  localparam int unsigned NARROW_PAD = NARROW_W - BYTE_W;
  localparam int unsigned UPPER_W    = XLEN - NARROW_W;

  logic [XLEN-1:0] wide_val;
  logic [XLEN-1:0] narrow_val;

  always_comb begin
    wide_val   = {{WIDE_PAD{byte_in[BYTE_W-1]}}, byte_in};
    narrow_val = {{UPPER_W{1'b0}}, {NARROW_PAD{byte_in[BYTE_W-1]}}, byte_in};
    result     = narrow ? narrow_val : wide_val;
  end

endmodule

// File: rtl/sbload_unit.sv
module sbload_unit
  import sbload_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned SP_ALIGN_BITS = 4,
  parameter int unsigned EL_W          = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn_word,
  output logic                 busy,
  output logic [REG_IDX_W-1:0] rf_rd_a_idx,
  input  logic [XLEN-1:0]      rf_rd_a_data,
  output logic [REG_IDX_W-1:0] rf_rd_b_idx,
  input  logic [XLEN-1:0]      rf_rd_b_data,
  input  logic [ADDR_W-1:0]    sp_value,
  input  logic                 sp_align_en,
  input  logic [EL_W-1:0]      cur_el,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic                 mem_req_priv,
  output logic                 mem_req_tagchk,
  input  logic                 mem_rsp_valid,
  input  logic [BYTE_W-1:0]    mem_rsp_data,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic                 flt_undef,
  output logic                 flt_sp_align
);

  localparam logic [REG_IDX_W-1:0] ZR_IDX = '1;
  localparam int unsigned          NARROW_W = XLEN / 2;

  st_e                  state_q, state_d;
  logic [INSN_W-1:0]    insn_q;
  logic                 priv_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 wb_en_q, wb_en_d;
  logic [REG_IDX_W-1:0] wb_idx_q;
  logic [XLEN-1:0]      wb_data_q;
  logic                 flt_undef_q, flt_undef_d;
  logic                 flt_sp_q, flt_sp_d;

  logic                 load_insn;
  logic                 load_addr;
  logic                 load_wb;

  dec_t                 dec;
  logic                 use_sp;
  logic [ADDR_W-1:0]    ea;
  logic                 misaligned;
  logic [XLEN-1:0]      sext_val;

  sbload_decode u_dec (
    .insn (insn_q),
    .dec  (dec)
  );

  assign use_sp = (dec.rn == ZR_IDX);

  sbload_agen #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (SP_ALIGN_BITS)
  ) u_agen (
    .use_sp     (use_sp),
    .sp_val     (sp_value),
    .base_reg   (rf_rd_a_data),
    .ofs_reg    (rf_rd_b_data),
    .mode       (dec.mode),
    .align_en   (sp_align_en),
    .ea         (ea),
    .misaligned (misaligned)
  );

  sbload_sext #(
    .XLEN     (XLEN),
    .NARROW_W (NARROW_W)
  ) u_sext (
    .byte_in (mem_rsp_data),
    .narrow  (dec.narrow),
    .result  (sext_val)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    load_insn   = 1'b0;
    load_addr   = 1'b0;
    load_wb     = 1'b0;
    wb_en_d     = 1'b0;
    flt_undef_d = 1'b0;
    flt_sp_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (insn_valid) begin
          load_insn = 1'b1;
          state_d   = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (!dec.legal) begin
          flt_undef_d = 1'b1;
          state_d     = ST_IDLE;
        end else if (misaligned) begin
          flt_sp_d = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          load_addr = 1'b1;
          state_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_req_ready) begin
          state_d = ST_RSP;
        end
      end
      ST_RSP: begin
        if (mem_rsp_valid) begin
          load_wb = 1'b1;
          wb_en_d = (dec.rt != ZR_IDX);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wb_en_q     <= 1'b0;
      flt_undef_q <= 1'b0;
      flt_sp_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      wb_en_q     <= wb_en_d;
      flt_undef_q <= flt_undef_d;
      flt_sp_q    <= flt_sp_d;
    end
  end

  // Data registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q    <= '0;
      priv_q    <= 1'b0;
      addr_q    <= '0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      if (load_insn) begin
        insn_q <= insn_word;
        priv_q <= (cur_el != '0);
      end
      if (load_addr) begin
        addr_q <= ea;
      end
      if (load_wb) begin
        wb_idx_q  <= dec.rt;
        wb_data_q <= sext_val;
      end
    end
  end

  assign busy           = (state_q != ST_IDLE);
  assign rf_rd_a_idx    = dec.rn;
  assign rf_rd_b_idx    = dec.rm;
  assign mem_req_valid  = (state_q == ST_REQ);
  assign mem_req_addr   = addr_q;
  assign mem_req_priv   = priv_q;
  assign mem_req_tagchk = 1'b1;
  assign wb_en          = wb_en_q;
  assign wb_idx         = wb_idx_q;
  assign wb_data        = wb_data_q;
  assign flt_undef      = flt_undef_q;
  assign flt_sp_align   = flt_sp_q;

endmodule

// File: rtl/sbload_unit_chk.sv
module sbload_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        wb_en,
  input logic [4:0]  wb_idx,
  input logic        flt_undef,
  input logic        flt_sp_align
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !busy) |=> busy);

  p_undef_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_undef |-> !$past(mem_req_valid));

  p_align_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_sp_align |-> !$past(mem_req_valid));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_no_zr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != 5'd31));

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, flt_undef, flt_sp_align}));

  p_outcome_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || flt_undef || flt_sp_align) |-> !busy);

endmodule

bind sbload_unit sbload_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_valid    (insn_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .wb_en         (wb_en),
  .wb_idx        (wb_idx),
  .flt_undef     (flt_undef),
  .flt_sp_align  (flt_sp_align)
);

// File: tb/tb_sbload_unit.sv
`timescale 1ns/1ps
module tb_sbload_unit;

  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic        busy;
  logic [4:0]  rf_rd_a_idx;
  logic [63:0] rf_rd_a_data;
  logic [4:0]  rf_rd_b_idx;
  logic [63:0] rf_rd_b_data;
  logic [63:0] sp_value;
  logic        sp_align_en;
  logic [1:0]  cur_el;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_req_priv;
  logic        mem_req_tagchk;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        flt_undef;
  logic        flt_sp_align;

  logic [63:0] regs [32];
  logic        byte_ovr_en;
  logic [7:0]  byte_ovr;

  int checks;
  int errors;

  assign rf_rd_a_data = regs[rf_rd_a_idx];
  assign rf_rd_b_data = regs[rf_rd_b_idx];

  sbload_unit dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .insn_valid     (insn_valid),
    .insn_word      (insn_word),
    .busy           (busy),
    .rf_rd_a_idx    (rf_rd_a_idx),
    .rf_rd_a_data   (rf_rd_a_data),
    .rf_rd_b_idx    (rf_rd_b_idx),
    .rf_rd_b_data   (rf_rd_b_data),
    .sp_value       (sp_value),
    .sp_align_en    (sp_align_en),
    .cur_el         (cur_el),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_priv   (mem_req_priv),
    .mem_req_tagchk (mem_req_tagchk),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .wb_en          (wb_en),
    .wb_idx         (wb_idx),
    .wb_data        (wb_data),
    .flt_undef      (flt_undef),
    .flt_sp_align   (flt_sp_align)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return byte_ovr_en ? byte_ovr : (a[7:0] ^ a[23:16] ^ a[47:40] ^ 8'h3C);
  endfunction

  function automatic bit is_legal(input logic [31:0] w);
    return ((w & 32'hFFA00C00) == 32'h38A00800) && w[14];
  endfunction

  function automatic logic [63:0] ext_ofs(input logic [2:0] opt, input logic [63:0] v);
    case (opt)
      3'b010:  return {32'h0, v[31:0]};
      3'b110:  return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [63:0] sext_exp(input logic [7:0] b, input bit narrow);
    if (narrow) return {32'h0, {24{b[7]}}, b};
    return {{56{b[7]}}, b};
  endfunction

  function automatic logic [31:0] mk(input bit opc0, input logic [4:0] rm, input logic [2:0] opt,
                                     input bit s, input logic [4:0] rn, input logic [4:0] rt);
    return 32'h38A00800 | ({31'h0, opc0} << 22) | ({27'h0, rm} << 16) | ({29'h0, opt} << 13)
           | ({31'h0, s} << 12) | ({27'h0, rn} << 5) | {27'h0, rt};
  endfunction

  // Kind: 0 write-back path, 1 undefined, 2 stack alignment fault
  task automatic run_one(input logic [31:0] w, input logic [63:0] sp, input bit aen,
                         input logic [1:0] el, input bit slow);
    int kind;
    logic [63:0] base, ea, exp_data;
    logic [7:0]  b;
    bit saw_req, hs_done, done, req_checked;
    int delay;
    logic [4:0] rn, rm, rt;
    rn = w[9:5]; rm = w[20:16]; rt = w[4:0];
    base = (rn == 5'd31) ? sp : regs[rn];
    ea = base + ext_ofs(w[15:13], regs[rm]);
    if (!is_legal(w)) kind = 1;
    else if (rn == 5'd31 && aen && sp[3:0] != 4'h0) kind = 2;
    else kind = 0;
    b = mem_byte(ea);
    exp_data = sext_exp(b, w[22]);

    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; sp_value = sp; sp_align_en = aen; cur_el = el;
    @(negedge clk);
    insn_valid = 1'b0; insn_word = $urandom;
    cur_el = 2'(el + 2'd1);
    chk(busy == 1'b1, "R1 busy after accept", {63'h0, busy}, 64'h1);
    saw_req = 0; hs_done = 0; done = 0; req_checked = 0;
    delay = slow ? int'($urandom % 4) : 0;
    for (int i = 0; i < 60 && !done; i++) begin
      if (!busy) begin
        done = 1;
      end else begin
        if (mem_req_valid) begin
          saw_req = 1;
          if (!req_checked) begin
            req_checked = 1;
            chk(mem_req_addr == ea, "R4 address", mem_req_addr, ea);
            chk(mem_req_priv == (el != 2'd0), "R10 privilege", {63'h0, mem_req_priv}, {63'h0, el != 2'd0});
            chk(mem_req_tagchk == 1'b1, "R10 tag check", {63'h0, mem_req_tagchk}, 64'h1);
          end
          mem_req_ready = slow ? 1'($urandom % 2) : 1'b1;
          if (mem_req_ready) hs_done = 1;
          @(negedge clk);
          mem_req_ready = 1'b0;
        end else if (hs_done) begin
          if (delay > 0) begin
            delay--;
            @(negedge clk);
          end else begin
            mem_rsp_valid = 1'b1; mem_rsp_data = b;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
          end
        end else begin
          @(negedge clk);
        end
      end
    end
    chk(done, "R11 completion", {63'h0, done}, 64'h1);
    chk(saw_req == (kind == 0), kind == 1 ? "R2 no access on undefined" : "R6 access presence",
        {63'h0, saw_req}, {63'h0, kind == 0});
    chk(flt_undef == (kind == 1), "R2 undefined fault", {63'h0, flt_undef}, {63'h0, kind == 1});
    chk(flt_sp_align == (kind == 2), "R6 alignment fault", {63'h0, flt_sp_align}, {63'h0, kind == 2});
    chk(wb_en == (kind == 0 && rt != 5'd31), "R9 write enable", {63'h0, wb_en}, {63'h0, kind == 0 && rt != 5'd31});
    if (kind == 0 && rt != 5'd31) begin
      chk(wb_idx == rt, "R9 destination", {59'h0, wb_idx}, {59'h0, rt});
      chk(wb_data == exp_data, "R8 sign-extended data", wb_data, exp_data);
    end
    @(negedge clk);
    chk(!(wb_en || flt_undef || flt_sp_align), "R11 single-cycle outcome",
        {61'h0, wb_en, flt_undef, flt_sp_align}, 64'h0);
  endtask

  function automatic logic [31:0] flip_fixed(input logic [31:0] w);
    int p;
    case ($urandom % 12)
      0: p = 31; 1: p = 30; 2: p = 29; 3: p = 28; 4: p = 27; 5: p = 26;
      6: p = 25; 7: p = 24; 8: p = 23; 9: p = 21; 10: p = 11; default: p = 10;
    endcase
    return w ^ (32'h1 << p);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] sp;
    void'($urandom(32'd20250));
    checks = 0; errors = 0;
    rst_n = 1'b0; insn_valid = 1'b0; insn_word = '0; sp_value = '0; sp_align_en = 1'b0;
    cur_el = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    byte_ovr_en = 1'b0; byte_ovr = '0;
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
    regs[31] = 64'hDEAD_0000_0000_0000;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_req_valid == 1'b0, "R1 reset idle", {62'h0, busy, mem_req_valid}, 64'h0);
    chk(!(wb_en || flt_undef || flt_sp_align), "R11 reset outcome clear",
        {61'h0, wb_en, flt_undef, flt_sp_align}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: offset modes with bit 12 set, negative low word (R3)
    regs[4] = 64'h0000_0000_0001_0000;
    regs[5] = 64'h1234_5678_FFFF_FFF0;
    run_one(mk(0, 5'd5, 3'b010, 1, 5'd4, 5'd7), 64'h0, 0, 2'd0, 0); // R3 zero-extend
    run_one(mk(0, 5'd5, 3'b110, 1, 5'd4, 5'd7), 64'h0, 0, 2'd1, 0); // R3 sign-extend
    run_one(mk(0, 5'd5, 3'b011, 1, 5'd4, 5'd7), 64'h0, 0, 2'd2, 0); // R3 full
    run_one(mk(0, 5'd5, 3'b111, 0, 5'd4, 5'd7), 64'h0, 0, 2'd3, 0); // R3 full signed
    // R8: both widths with negative and positive bytes
    byte_ovr_en = 1'b1;
    byte_ovr = 8'h80; run_one(mk(0, 5'd5, 3'b011, 0, 5'd4, 5'd8), 64'h0, 0, 2'd1, 0);
    byte_ovr = 8'h80; run_one(mk(1, 5'd5, 3'b011, 0, 5'd4, 5'd8), 64'h0, 0, 2'd1, 0);
    byte_ovr = 8'h7F; run_one(mk(1, 5'd5, 3'b011, 0, 5'd4, 5'd8), 64'h0, 0, 2'd1, 0);
    byte_ovr = 8'hFF; run_one(mk(0, 5'd5, 3'b011, 0, 5'd4, 5'd8), 64'h0, 0, 2'd1, 1);
    byte_ovr_en = 1'b0;
    // R5/R6: stack pointer as base
    run_one(mk(0, 5'd5, 3'b011, 0, 5'd31, 5'd9), 64'h0000_7FF0_0000_1000, 1, 2'd0, 0);
    run_one(mk(0, 5'd5, 3'b011, 0, 5'd31, 5'd9), 64'h0000_7FF0_0000_1008, 1, 2'd0, 0);
    run_one(mk(0, 5'd5, 3'b011, 0, 5'd31, 5'd9), 64'h0000_7FF0_0000_1008, 0, 2'd0, 0);
    // R6 priority: undefined beats misalignment
    run_one(mk(0, 5'd5, 3'b001, 0, 5'd31, 5'd9), 64'h0000_7FF0_0000_1001, 1, 2'd0, 0);
    // R2: option bit 1 clear, broken fixed bit
    run_one(mk(0, 5'd5, 3'b000, 0, 5'd4, 5'd9), 64'h0, 0, 2'd0, 0);
    run_one(mk(0, 5'd5, 3'b100, 0, 5'd4, 5'd9), 64'h0, 0, 2'd0, 0);
    run_one(flip_fixed(mk(0, 5'd5, 3'b011, 0, 5'd4, 5'd9)), 64'h0, 0, 2'd0, 0);
    // R9: destination 31
    run_one(mk(1, 5'd5, 3'b011, 0, 5'd4, 5'd31), 64'h0, 0, 2'd0, 1);
    // R4: wrap-around
    regs[6] = 64'hFFFF_FFFF_FFFF_FFFE; regs[10] = 64'h5;
    run_one(mk(0, 5'd10, 3'b011, 0, 5'd6, 5'd11), 64'h0, 0, 2'd0, 0);

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = mk(1'($urandom), 5'($urandom), 3'($urandom), 1'($urandom),
             ($urandom % 4 == 0) ? 5'd31 : 5'($urandom), 5'($urandom));
      if ($urandom % 10 == 0) w = flip_fixed(w);
      sp = {$urandom, $urandom};
      if ($urandom % 2 == 0) sp[3:0] = 4'h0;
      run_one(w, sp, 1'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule